// File: doc/BRIEF.md
# Single-wire slave reset and presence responder

This block sits on the slave side of an open-drain single-wire bus. It watches the line and measures how long each low pulse from the master lasts, counted on a one-microsecond tick. When a long enough low pulse ends, it reports that a reset was detected. It then waits a short fixed time and pulls the line low for a fixed period, the presence pulse, which tells the master that a slave is present.

The responder runs at one of two speeds. An external request, usually from a command decoder further up, switches it to overdrive speed. At that speed a much shorter low pulse counts as a reset, and the presence pulse is timed much tighter. A low pulse of standard reset length always qualifies as a reset at either speed and returns the block to standard speed. Data time slots, command decoding and the pull-up are handled elsewhere.

Top module: `owpr_responder`

## Requirements
- R1: After reset, `line_pull`, `reset_det` and `ovd_mode` are all 0.
- R2: At standard speed, a low period of at least 480 ticks qualifies as a reset when the line next rises. It produces exactly one single-cycle `reset_det` pulse. Shorter low periods produce no `reset_det` and no presence pulse.
- R3: After a standard-speed reset, `line_pull` rises on the 30th tick counted from the cycle after `reset_det`.
- R4: At standard speed, `line_pull` stays high for exactly 120 ticks and then drops.
- R5: A one-cycle high on `ovd_enter` sets `ovd_mode` to 1 in the next cycle.
- R6: In overdrive mode, a low period of at least 48 ticks but under 480 ticks qualifies as a reset. Its presence pulse uses a 3-tick wait and a 12-tick low, and `ovd_mode` stays 1. Low periods under 48 ticks produce no `reset_det`.
- R7: A low period of at least 480 ticks clears `ovd_mode` to 0 and produces a presence pulse with standard timing, even when the block was in overdrive mode.
- R8: Line activity during the presence wait or the presence low has no effect. No `reset_det` is produced, the presence timing does not change, and the line released at the end of the presence pulse is not taken as a reset.
- R9: `line_in` passes through two synchronizer flops. `reset_det` is high in the third clock cycle after the cycle in which `line_in` rises, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_us | input | 1 | One-cycle strobe, once per microsecond |
| line_in | input | 1 | Raw level of the bus line, asynchronous |
| ovd_enter | input | 1 | Request to switch to overdrive speed |
| line_pull | output | 1 | Enable for the open-drain pull-down |
| reset_det | output | 1 | One-cycle strobe when a qualified reset ends |
| ovd_mode | output | 1 | 1 while the responder runs at overdrive speed |

## Verification
The bench tests low pulses just below and just above both reset thresholds. A design with an off-by-a-few threshold, or one that applies the overdrive threshold at standard speed, fires on the wrong side. Presence wait and low are counted in ticks at both speeds, so a counter that ends one phase a tick early or late is caught. A standard-length reset is sent while in overdrive; a design that keeps overdrive, or times that presence at overdrive speed, reports the wrong mode or duration. The master also pulls the line low during the presence wait; a design that keeps listening then reports a spurious reset or shifts the presence pulse.

// File: rtl/owpr_pkg.sv
package owpr_pkg;

  typedef enum logic [1:0] {PH_IDLE, PH_WAIT, PH_PULL} phase_t;
  typedef enum logic [1:0] {RK_NONE, RK_OVD, RK_STD} rst_kind_t;

  // Classify a finished low period by its length in ticks.
  function automatic rst_kind_t classify(input int unsigned low_us,
                                         input logic ovd,
                                         input int unsigned std_min,
                                         input int unsigned ovd_min);
    if (low_us >= std_min) return RK_STD;
    if (ovd && (low_us >= ovd_min)) return RK_OVD;
    return RK_NONE;
  endfunction

  // Length in ticks of a presence phase at the chosen speed.
  function automatic int unsigned phase_len(input phase_t ph, input logic ovd,
                                            input int unsigned std_wait,
                                            input int unsigned std_pull,
                                            input int unsigned ovd_wait,
                                            input int unsigned ovd_pull);
    case (ph)
      PH_WAIT: return ovd ? ovd_wait : std_wait;
      PH_PULL: return ovd ? ovd_pull : std_pull;
      default: return 32'd1;
    endcase
  endfunction

endpackage

// File: rtl/owpr_sync.sv
module owpr_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '1;
    else        sh <= {sh[STAGES-2:0], d};
  end

  assign q = sh[STAGES-1];
endmodule

// File: rtl/owpr_low_meter.sv
module owpr_low_meter #(
  parameter int unsigned CW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          line_s,
  input  logic          tick_us,
  input  logic          hold,
  output logic [CW-1:0] low_cnt,
  output logic          rise_ev
);
  localparam logic [CW-1:0] SAT = '1;

  logic line_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) line_q <= 1'b1;
    else        line_q <= line_s;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        low_cnt <= '0;
    else if (hold || line_s)           low_cnt <= '0;
    else if (tick_us && low_cnt != SAT) low_cnt <= low_cnt + 1'b1;
  end

  assign rise_ev = line_s & ~line_q;
endmodule

// File: rtl/owpr_presence_seq.sv
module owpr_presence_seq
  import owpr_pkg::*;
#(
  parameter int unsigned STD_WAIT_US = 30,
  parameter int unsigned STD_PULL_US = 120,
  parameter int unsigned OVD_WAIT_US = 3,
  parameter int unsigned OVD_PULL_US = 12,
  parameter int unsigned CW          = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_us,
  input  logic start,
  input  logic start_ovd,
  output logic pull,
  output logic busy,
  output logic in_wait
);
  phase_t         phase;
  logic [CW-1:0]  cnt;
  logic           speed_ovd;
  logic           last_tick;

  assign last_tick = (32'(cnt) == phase_len(phase, speed_ovd, STD_WAIT_US,
                                            STD_PULL_US, OVD_WAIT_US,
                                            OVD_PULL_US) - 32'd1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= PH_IDLE;
      cnt       <= '0;
      speed_ovd <= 1'b0;
    end else if (start && phase == PH_IDLE) begin
      phase     <= PH_WAIT;
      cnt       <= '0;
      speed_ovd <= start_ovd;
    end else if (tick_us && phase != PH_IDLE) begin
      if (last_tick) begin
        cnt   <= '0;
        phase <= (phase == PH_WAIT) ? PH_PULL : PH_IDLE;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign pull    = (phase == PH_PULL);
  assign busy    = (phase != PH_IDLE);
  assign in_wait = (phase == PH_WAIT);
endmodule

// File: rtl/owpr_responder.sv
module owpr_responder
  import owpr_pkg::*;
#(
  parameter int unsigned STD_RESET_US = 480,
  parameter int unsigned OVD_RESET_US = 48,
  parameter int unsigned STD_WAIT_US  = 30,
  parameter int unsigned STD_PULL_US  = 120,
  parameter int unsigned OVD_WAIT_US  = 3,
  parameter int unsigned OVD_PULL_US  = 12,
  parameter int unsigned SYNC_STAGES  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_us,
  input  logic line_in,
  input  logic ovd_enter,
  output logic line_pull,
  output logic reset_det,
  output logic ovd_mode
);
  localparam int unsigned LCW     = $clog2(STD_RESET_US + 2);
  localparam int unsigned MAX_STD = (STD_WAIT_US > STD_PULL_US) ? STD_WAIT_US : STD_PULL_US;
  localparam int unsigned MAX_OVD = (OVD_WAIT_US > OVD_PULL_US) ? OVD_WAIT_US : OVD_PULL_US;
  localparam int unsigned MAX_LEN = (MAX_STD > MAX_OVD) ? MAX_STD : MAX_OVD;
  localparam int unsigned PCW     = $clog2(MAX_LEN + 1);

  logic           line_s;
  logic [LCW-1:0] low_cnt;
  logic           rise_ev;
  logic           busy;
  logic           in_wait;
  rst_kind_t      kind;
  logic           rst_ev;
  logic           std_ev;

  owpr_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(line_in), .q(line_s)
  );

  owpr_low_meter #(.CW(LCW)) u_meter (
    .clk(clk), .rst_n(rst_n), .line_s(line_s), .tick_us(tick_us),
    .hold(busy), .low_cnt(low_cnt), .rise_ev(rise_ev)
  );

  assign kind   = classify(32'(low_cnt), ovd_mode, STD_RESET_US, OVD_RESET_US);
  assign rst_ev = rise_ev & ~busy & (kind != RK_NONE);
  assign std_ev = rst_ev & (kind == RK_STD);

  owpr_presence_seq #(
    .STD_WAIT_US(STD_WAIT_US), .STD_PULL_US(STD_PULL_US),
    .OVD_WAIT_US(OVD_WAIT_US), .OVD_PULL_US(OVD_PULL_US), .CW(PCW)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .tick_us(tick_us), .start(rst_ev),
    .start_ovd(kind == RK_OVD), .pull(line_pull), .busy(busy),
    .in_wait(in_wait)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reset_det <= 1'b0;
      ovd_mode  <= 1'b0;
    end else begin
      reset_det <= rst_ev;
      if (std_ev)         ovd_mode <= 1'b0;
      else if (ovd_enter) ovd_mode <= 1'b1;
    end
  end
endmodule

// File: rtl/owpr_responder_chk.sv
module owpr_responder_chk (
  input logic clk,
  input logic rst_n,
  input logic tick_us,
  input logic ovd_enter,
  input logic line_pull,
  input logic reset_det,
  input logic ovd_mode,
  input logic rst_ev,
  input logic std_ev,
  input logic in_wait
);
  a_r2_strobe_follows_event: assert property (@(posedge clk) disable iff (!rst_n)
    rst_ev |=> reset_det);
  a_r2_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    reset_det |=> !reset_det);
  a_r3_wait_before_pull: assert property (@(posedge clk) disable iff (!rst_n)
    reset_det |-> (in_wait && !line_pull));
  a_r4_pull_rise_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(line_pull) |-> $past(tick_us));
  a_r4_pull_fall_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(line_pull) |-> $past(tick_us));
  a_r5_enter_sets_mode: assert property (@(posedge clk) disable iff (!rst_n)
    (ovd_enter && !std_ev) |=> ovd_mode);
  a_r7_std_clears_mode: assert property (@(posedge clk) disable iff (!rst_n)
    std_ev |=> !ovd_mode);
  a_r8_no_detect_while_pulling: assert property (@(posedge clk) disable iff (!rst_n)
    line_pull |-> !reset_det);
endmodule

bind owpr_responder owpr_responder_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick_us(tick_us), .ovd_enter(ovd_enter),
  .line_pull(line_pull), .reset_det(reset_det), .ovd_mode(ovd_mode),
  .rst_ev(rst_ev), .std_ev(std_ev), .in_wait(in_wait)
);

// File: tb/owpr_responder_bench.sv
`timescale 1ns/1ps
module owpr_responder_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_us = 1'b0;
  logic m_low = 1'b0;
  logic ovd_enter = 1'b0;
  logic line_pull, reset_det, ovd_mode;
  wire  line_in = ~(m_low | line_pull);

  int checks = 0;
  int fails = 0;
  bit ovd_exp = 1'b0;
  int tphase = 0;

  always #5 clk = ~clk;

  owpr_responder u_owpr_responder (
    .clk(clk), .rst_n(rst_n), .tick_us(tick_us), .line_in(line_in),
    .ovd_enter(ovd_enter), .line_pull(line_pull), .reset_det(reset_det),
    .ovd_mode(ovd_mode)
  );

  // one tick every four clocks, changed at the falling edge
  initial begin
    forever begin
      @(negedge clk);
      tphase = (tphase + 1) % 4;
      tick_us = (tphase == 0);
    end
  end

  function automatic int exp_kind(int low_us, bit ovd);
    if (low_us >= 480) return 2;
    if (ovd && low_us >= 48) return 1;
    return 0;
  endfunction
  function automatic int exp_wait(int kind);
    return (kind == 1) ? 3 : 30;
  endfunction
  function automatic int exp_pull(int kind);
    return (kind == 1) ? 12 : 120;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic hold_low(input int us);
    int n = 0;
    step();
    m_low = 1'b1;
    while (n < us) begin
      if (tick_us) n++;
      step();
    end
    m_low = 1'b0;
  endtask

  task automatic run_cycle(input int low_us, input int glitch, input string tag);
    int kind = exp_kind(low_us, ovd_exp);
    int ph = 0;
    int ticks = 0;
    int det_at = 0;
    int det_cnt = 0;
    int wait_t = -1;
    int pull_t = -1;
    int pull_seen = 0;
    int i = 0;
    hold_low(low_us);
    while (ph != 3 && i < 3000) begin
      step();
      i++;
      if (reset_det) begin
        det_cnt++;
        if (det_at == 0) det_at = i;
      end
      if (line_pull) pull_seen++;
      case (ph)
        0: if (reset_det) begin ph = 1; ticks = 0; end
        1: if (line_pull) begin wait_t = ticks; ph = 2; ticks = 0; end
        2: if (!line_pull) begin pull_t = ticks; ph = 3; end
        default: ;
      endcase
      if (ph == 0 && kind == 0 && i >= 200) ph = 3;
      if ((ph == 1 || ph == 2) && tick_us) ticks++;
      if (ph == 1 && glitch > 0) begin
        if (ticks == 2) m_low = 1'b1;
        if (ticks == 2 + glitch) m_low = 1'b0;
      end
    end
    m_low = 1'b0;
    for (int k = 0; k < 40; k++) begin
      step();
      if (reset_det) det_cnt++;
    end
    if (kind == 2) ovd_exp = 1'b0;
    if (kind == 0) begin
      chk(det_cnt == 0, {tag, " no reset_det"}, det_cnt, 0);
      chk(pull_seen == 0, {tag, " no presence"}, pull_seen, 0);
    end else begin
      chk(det_at == 3, {tag, " R9 reset_det cycle"}, det_at, 3);
      chk(det_cnt == 1, {tag, " single strobe"}, det_cnt, 1);
      chk(wait_t == exp_wait(kind), {tag, " presence wait"}, wait_t, exp_wait(kind));
      chk(pull_t == exp_pull(kind), {tag, " presence low"}, pull_t, exp_pull(kind));
    end
    chk(ovd_mode == ovd_exp, {tag, " ovd_mode"}, int'(ovd_mode), int'(ovd_exp));
  endtask

  task automatic go_ovd();
    step();
    ovd_enter = 1'b1;
    step();
    ovd_enter = 1'b0;
    ovd_exp = 1'b1;
    chk(ovd_mode == 1'b1, "R5 ovd_enter sets mode", int'(ovd_mode), 1);
  endtask

  initial begin
    #1_900_000;
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0a11));
    repeat (4) step();
    chk(line_pull == 1'b0, "R1 line_pull at reset", int'(line_pull), 0);
    chk(reset_det == 1'b0, "R1 reset_det at reset", int'(reset_det), 0);
    chk(ovd_mode == 1'b0, "R1 ovd_mode at reset", int'(ovd_mode), 0);
    rst_n = 1'b1;
    repeat (8) step();

    run_cycle(484, 0, "R2 R3 R4 std above threshold");
    run_cycle(476, 0, "R2 std below threshold");
    run_cycle(100, 0, "R2 std short low");
    go_ovd();
    run_cycle(52, 0, "R6 ovd above threshold");
    run_cycle(44, 0, "R6 ovd below threshold");
    run_cycle(200, 0, "R6 ovd mid low");
    run_cycle(500, 0, "R7 std reset leaves ovd");
    run_cycle(600, 15, "R8 glitch during wait");

    for (int it = 0; it < 14; it++) begin
      int r = int'($urandom % 8);
      int len;
      if (r == 0) go_ovd();
      else begin
        case (r % 3)
          0: len = 8 + int'($urandom % 33);
          1: len = 56 + int'($urandom % 405);
          default: len = 490 + int'($urandom % 151);
        endcase
        if (exp_kind(len, ovd_exp) == 2 && (r & 1)) run_cycle(len, 12, "R8 random glitch");
        else run_cycle(len, 0, "R2 R6 R7 random");
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule